// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block sequences the sleep request of a synchronous memory. The sleep input is registered on the clock like every other control input. A request is not honoured at once. For a short entry window the memory keeps taking commands. After that window it stops sampling everything except the sleep input, reports that the low-power state has been reached, and holds its data outputs at high impedance. When the request is withdrawn, the low-power indication clears on that same edge. Command sampling comes back only after a recovery window has run.

The controller uses four named states. `ST_AWAKE` is normal operation. `ST_ENTER` is the entry window. `ST_SNOOZE` is the low-power state. `ST_WAKE` is the recovery window. The transitions are:

- **go_enter**: `ST_AWAKE` to `ST_ENTER`, on a sampled sleep request.
- **abort**: `ST_ENTER` to `ST_AWAKE`, when the request drops.
- **settle**: `ST_ENTER` to `ST_SNOOZE`, when the entry window ends with the request still high.
- **release**: `ST_SNOOZE` to `ST_WAKE`, when the request drops.
- **resume**: `ST_WAKE` to `ST_AWAKE`, when the recovery window ends.

In both windows only reads or deselects are legal. A write issued in either window is dropped, and a violation flag latches until reset.

Top module: `snz_seq`

## Requirements
- R1: After reset the block is in `ST_AWAKE`: `in_accept`=1, `lowpwr`=0, `out_hiz`=0, `viol`=0.
- R2: After the edge that samples `sleep_in`=1 in `ST_AWAKE`, `in_accept` stays 1 for ENTRY_CYC (2) cycles. It is then 0 until recovery completes.
- R3: `lowpwr` rises ENTRY_CYC (2) edges after the edge that sampled `sleep_in`=1 in `ST_AWAKE`, provided the request stays high. It then stays 1 while the request is held.
- R4: `lowpwr` falls immediately after the first edge that samples `sleep_in`=0 in `ST_SNOOZE`.
- R5: `in_accept` returns to 1 EXIT_CYC (2) edges after the edge that sampled `sleep_in`=0 in `ST_SNOOZE`. In the meantime all commands are ignored (`cmd_accept`=0).
- R6: `out_hiz` is 1 in `ST_SNOOZE` and `ST_WAKE`, and 0 whenever `in_accept`=1.
- R7: `cmd_accept` equals `cmd_valid` while `in_accept`=1. The exception is a write (`cmd_write`=1) during the entry window, which is dropped (`cmd_accept`=0).
- R8: A command with `cmd_valid`=1 and `cmd_write`=1 in the entry or recovery window sets `viol` on the next edge, and `viol` then stays 1 until reset. A write while in `ST_SNOOZE` leaves `viol` unchanged.
- R9: If `sleep_in` is sampled 0 during the entry window, the block returns to `ST_AWAKE`. The next sampled request restarts the full ENTRY_CYC count.
- R10: `sleep_in` has no effect during the recovery window. A request still high when the window ends starts a new entry on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_in | input | 1 | Sleep request, sampled each edge |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_write | input | 1 | The presented command is a write (0 = read) |
| in_accept | output | 1 | Inputs are being sampled |
| cmd_accept | output | 1 | The presented command is passed to the memory |
| lowpwr | output | 1 | Low-power state reached |
| out_hiz | output | 1 | Data outputs forced to high impedance |
| viol | output | 1 | Sticky flag: write issued inside a window |

## Verification
The bench builds the block with ENTRY_CYC=2 and EXIT_CYC=2. With these values every window edge can be checked against the stated cycle counts. These small values also let a short stimulus cover a request that toggles inside the entry window, a request held through the whole recovery window, and writes placed in each of the four states. A mid-run reset shows that the sticky violation flag clears only through reset.

// File: rtl/snz_pkg.sv
`timescale 1ns/1ps
package snz_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ENTER  = 2'd1,
        ST_SNOOZE = 2'd2,
        ST_WAKE   = 2'd3
    } snz_state_t;
endpackage

// File: rtl/snz_win_timer.sv
`timescale 1ns/1ps
module snz_win_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign done = (cnt == limit);
endmodule

// File: rtl/snz_cmd_gate.sv
`timescale 1ns/1ps
module snz_cmd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_write,
    input  logic accepting,
    input  logic entry_win,
    input  logic recov_win,
    output logic cmd_accept,
    output logic viol
);
    logic bad_write;

    assign bad_write  = cmd_valid & cmd_write & (entry_win | recov_win);
    assign cmd_accept = cmd_valid & accepting & ~(cmd_write & entry_win);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         viol <= 1'b0;
        else if (bad_write) viol <= 1'b1;
    end
endmodule

// File: rtl/snz_seq.sv
`timescale 1ns/1ps
module snz_seq
    import snz_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_in,
    input  logic cmd_valid,
    input  logic cmd_write,
    output logic in_accept,
    output logic cmd_accept,
    output logic lowpwr,
    output logic out_hiz,
    output logic viol
);
    localparam int MAXW = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0] ENTRY_LIM = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXIT_LIM  = CW'(EXIT_CYC - 1);

    snz_state_t state, state_nx;
    logic       win_done;
    logic       entry_win, recov_win;
    logic [CW-1:0] win_limit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AWAKE:  if (sleep_in) state_nx = ST_ENTER;
            ST_ENTER:  if (!sleep_in)    state_nx = ST_AWAKE;
                       else if (win_done) state_nx = ST_SNOOZE;
            ST_SNOOZE: if (!sleep_in) state_nx = ST_WAKE;
            ST_WAKE:   if (win_done)  state_nx = ST_AWAKE;
        endcase
    end

    // per-state outputs
    always_comb begin
        in_accept = 1'b0;
        lowpwr    = 1'b0;
        out_hiz   = 1'b0;
        entry_win = 1'b0;
        recov_win = 1'b0;
        unique case (state)
            ST_AWAKE:  in_accept = 1'b1;
            ST_ENTER:  begin in_accept = 1'b1; entry_win = 1'b1; end
            ST_SNOOZE: begin lowpwr = 1'b1; out_hiz = 1'b1; end
            ST_WAKE:   begin out_hiz = 1'b1; recov_win = 1'b1; end
        endcase
    end

    assign win_limit = entry_win ? ENTRY_LIM : EXIT_LIM;

    snz_win_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~(entry_win | recov_win)),
        .limit (win_limit),
        .done  (win_done)
    );

    snz_cmd_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .accepting  (in_accept),
        .entry_win  (entry_win),
        .recov_win  (recov_win),
        .cmd_accept (cmd_accept),
        .viol       (viol)
    );
endmodule

// File: rtl/snz_seq_chk.sv
`timescale 1ns/1ps
module snz_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_in,
    input logic cmd_valid,
    input logic cmd_write,
    input logic in_accept,
    input logic cmd_accept,
    input logic lowpwr,
    input logic out_hiz,
    input logic viol
);
    // R4
    lowpwr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr && !sleep_in |=> !lowpwr);

    // R3
    lowpwr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lowpwr) |-> $past(sleep_in));

    // R6
    hiz_vs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hiz && in_accept));

    // R6
    lowpwr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr |-> out_hiz);

    // R7
    accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> (in_accept && cmd_valid));

    // R8
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    // R8
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> $past(cmd_valid && cmd_write && !cmd_accept && !lowpwr));
endmodule

bind snz_seq snz_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_in   (sleep_in),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .in_accept  (in_accept),
    .cmd_accept (cmd_accept),
    .lowpwr     (lowpwr),
    .out_hiz    (out_hiz),
    .viol       (viol)
);

// File: tb/snz_seq_bench.sv
`timescale 1ns/1ps
module snz_seq_bench;
    localparam int ENTRY_N = 2;
    localparam int EXIT_N  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_in = 1'b0, cmd_valid = 1'b0, cmd_write = 1'b0;
    logic in_accept, cmd_accept, lowpwr, out_hiz, viol;

    int n_chk = 0;
    int n_fail = 0;

    // reference model: 0 awake, 1 entering, 2 snoozing, 3 waking
    int m_mode = 0;
    int m_cnt  = 0;
    bit m_viol = 0;

    always #2 clk = ~clk;

    snz_seq #(.ENTRY_CYC(ENTRY_N), .EXIT_CYC(EXIT_N)) u_snz_seq (
        .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .in_accept(in_accept), .cmd_accept(cmd_accept),
        .lowpwr(lowpwr), .out_hiz(out_hiz), .viol(viol)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit acc;
        acc = (m_mode <= 1);
        chk("R2/R5 in_accept", in_accept, acc);
        chk("R3/R4 lowpwr", lowpwr, m_mode == 2);
        chk("R6 out_hiz", out_hiz, m_mode >= 2);
        chk("R7 cmd_accept", cmd_accept,
            cmd_valid && acc && !(cmd_write && m_mode == 1));
        chk("R8 viol", viol, m_viol);
    endtask

    task automatic step(input logic s, input logic v, input logic w);
        @(negedge clk);
        sleep_in = s; cmd_valid = v; cmd_write = w;
        #1;
        compare_all();
        @(posedge clk);
        if (v && w && (m_mode == 1 || m_mode == 3)) m_viol = 1;
        case (m_mode)
            0: if (s) begin m_mode = 1; m_cnt = 0; end
            1: if (!s) m_mode = 0;
               else if (m_cnt == ENTRY_N - 1) m_mode = 2;
               else m_cnt++;
            2: if (!s) begin m_mode = 3; m_cnt = 0; end
            default: if (m_cnt == EXIT_N - 1) m_mode = 0; else m_cnt++;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sleep_in = 0; cmd_valid = 0; cmd_write = 0;
        m_mode = 0; m_cnt = 0; m_viol = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 in_accept", in_accept, 1'b1);
        chk("R1 lowpwr", lowpwr, 1'b0);
        chk("R1 out_hiz", out_hiz, 1'b0);
        chk("R1 viol", viol, 1'b0);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R7 normal reads and writes
        step(0,1,0); step(0,1,1); step(0,0,1); step(0,1,0);
        // R2 R3 entry with reads, R8 write in snooze gives no violation
        step(1,1,0); step(1,1,0); step(1,1,0);
        step(1,1,1); step(1,1,1); step(1,0,0);
        // R4 exit, R10 request held through recovery, R5 commands ignored
        step(0,1,0); step(1,1,0); step(1,1,0);
        step(1,1,0); step(1,1,0); step(1,1,0); step(1,0,0);
        step(0,0,0); step(0,1,0); step(0,1,0); step(0,1,0); step(0,1,1);
        // R9 toggle inside entry window then full restart
        step(1,1,0); step(0,1,0); step(1,1,0); step(1,1,0);
        step(1,0,0); step(1,0,0);
        // R8 write in recovery window sets sticky flag
        step(0,0,0); step(0,1,1); step(0,0,0); step(0,1,0);
        step(0,0,0); step(0,0,0);
        // R1 flag cleared by reset only; R7 R8 write in entry window dropped
        do_reset();
        step(0,0,0); step(1,0,0); step(1,1,1); step(1,0,0);
        step(1,0,0); step(0,0,0); step(0,0,0); step(0,0,0); step(0,1,1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule